// File: doc/BRIEF.md
# Windowed Register File with Call/Return Rotation

This block is the integer register file of a processor core that passes procedure parameters through overlapping register windows. Software always addresses 32 logical registers. Ten of them are global and hold the same value in every window. The other 22 belong to the current window and are split into three groups. The first is six output registers for arguments going to a callee. The second is ten private locals. The third is six input registers that receive arguments from the caller. A window pointer picks which slice of the physical storage the windowed registers map to. The physical storage holds 8 windows in a ring and has 138 registers in total.

A call strobe moves the pointer one window down the ring, and a return strobe moves it back up. The caller's output registers and the callee's input registers are the same physical cells, so arguments reach the callee without any memory traffic. One window in the ring is always marked as not resident. A call into that window, or a return into it, would cross a window that memory must save or restore. In that case the block raises an overflow or underflow indication. It reports which window is involved, freezes the pointer and waits for an acknowledge from the trap handler. Moving the data to and from memory is the handler's job and is outside this block.

The block has two combinational read ports and one write port. The write takes effect on the clock edge, and a read of the register being written in the same cycle returns the new data.

Top module: `rwin_regfile`

## Requirements
- R1: Logical registers r1 to r9 are global: a value written to one of them reads back the same under every window pointer value.
- R2: Logical register r0 always reads as zero, and a write to r0 leaves every register unchanged.
- R3: Both read ports are combinational. When a read address equals the write address of an enabled write in the same cycle (address not r0), the port returns the write data.
- R4: Windowed layout: r10 to r15 are outputs, r16 to r25 are locals and r26 to r31 are inputs. Output r(10+k) of window w is the same physical register as input r(26+k) of window w-1 mod 8. Locals of different windows are distinct.
- R5: With no trap pending, call_i high and ret_i low makes cwp_o one lower (mod 8) at the next clock edge, unless R7 applies. ret_i high and call_i low makes cwp_o one higher (mod 8), unless R9 applies.
- R6: After synchronous reset, cwp_o is 0, the non-resident mark is window 1, ovf_o and unf_o are low, trap_win_o is 0 and every register reads as zero.
- R7: A call whose target window equals the non-resident mark leaves cwp_o unchanged and raises ovf_o at the next edge. While ovf_o is high, trap_win_o gives the oldest resident window (mark - 1 mod 8), which must be saved. ovf_o stays high until ack_i.
- R8: ack_i while ovf_o is high clears ovf_o at the next edge, completes the call (cwp_o decremented) and moves the mark down by one window.
- R9: A return whose target window equals the mark leaves cwp_o unchanged and raises unf_o. trap_win_o gives the mark (the window to restore). ack_i clears unf_o, completes the return and moves the mark up by one window.
- R10: call_i and ret_i together have no effect. call_i and ret_i while a trap is pending have no effect. ack_i with no trap pending has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| call_i | input | 1 | Procedure call strobe |
| ret_i | input | 1 | Procedure return strobe |
| ack_i | input | 1 | Trap handler finished spill or fill |
| ra_i | input | 5 | Read port A logical address |
| rb_i | input | 5 | Read port B logical address |
| rd_a_o | output | 32 | Read port A data |
| rd_b_o | output | 32 | Read port B data |
| we_i | input | 1 | Write enable |
| wa_i | input | 5 | Write logical address |
| wd_i | input | 32 | Write data |
| cwp_o | output | 3 | Current window pointer |
| ovf_o | output | 1 | Window overflow: spill needed |
| unf_o | output | 1 | Window underflow: fill needed |
| trap_win_o | output | 3 | Window to spill or fill while a trap is pending |

## Verification
The hardest situation to reach is the wrap of the non-resident mark. That takes an overflow, its acknowledge, then a run of returns all the way round the ring until an underflow occurs at the moved mark. The bench reaches it with a directed walk: six calls, a seventh that overflows, an acknowledge, then seven returns. A long random run follows, with call and return weights close enough that the pointer crosses the mark in both directions many times. During that run, acknowledges arrive after random delays, and strobes are deliberately issued while a trap is pending.

// File: rtl/rwin_pkg.sv
package rwin_pkg;

    localparam int DEF_NWIN  = 8;
    localparam int DEF_NGLOB = 10;
    localparam int DEF_NIO   = 6;
    localparam int DEF_NLOC  = 10;
    localparam int DEF_DW    = 32;
    localparam int LREGS     = 32;
    localparam int LAW       = 5;

    typedef enum logic [1:0] {
        WS_RUN   = 2'd0,
        WS_SPILL = 2'd1,
        WS_FILL  = 2'd2
    } win_state_e;

    typedef struct packed {
        logic call;
        logic ret;
        logic ack;
    } win_cmd_t;

endpackage

// File: rtl/rwin_map.sv
module rwin_map
    import rwin_pkg::*;
#(
    parameter int NWIN  = DEF_NWIN,
    parameter int NGLOB = DEF_NGLOB,
    parameter int NIO   = DEF_NIO,
    parameter int NLOC  = DEF_NLOC,
    parameter int WW    = $clog2(NWIN),
    parameter int PW    = 8
) (
    input  logic [LAW-1:0] lreg,
    input  logic [WW-1:0]  cwp,
    output logic [PW-1:0]  preg
);
    localparam int BANK   = NIO + NLOC;
    localparam int OUT_LO = NGLOB;
    localparam int LOC_LO = NGLOB + NIO;
    localparam int IN_LO  = NGLOB + NIO + NLOC;

    int r;
    int w;
    int wprev;
    int p;

    always_comb begin
        r     = int'(lreg);
        w     = int'(cwp);
        wprev = (w + NWIN - 1) % NWIN;
        if (r < OUT_LO) begin
            p = r;
        end else if (r < LOC_LO) begin
            // outputs live in the input slice of the next-deeper window
            p = NGLOB + wprev * BANK + (r - OUT_LO);
        end else if (r < IN_LO) begin
            p = NGLOB + w * BANK + NIO + (r - LOC_LO);
        end else begin
            p = NGLOB + w * BANK + (r - IN_LO);
        end
        preg = PW'(p);
    end
endmodule

// File: rtl/rwin_ctrl.sv
module rwin_ctrl
    import rwin_pkg::*;
#(
    parameter int NWIN  = DEF_NWIN,
    parameter int WW    = $clog2(NWIN),
    parameter int MARK0 = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  win_cmd_t      cmd,
    output logic [WW-1:0] cwp_o,
    output logic          ovf_o,
    output logic          unf_o,
    output logic [WW-1:0] trap_win_o
);
    localparam logic [WW-1:0] ONE      = WW'(1);
    localparam logic [WW-1:0] MARK_RST = WW'(MARK0);

    win_state_e    st;
    logic [WW-1:0] cwp;
    logic [WW-1:0] mark;
    logic [WW-1:0] cwp_dn;
    logic [WW-1:0] cwp_up;
    logic          do_call;
    logic          do_ret;

    assign cwp_dn  = cwp - ONE;
    assign cwp_up  = cwp + ONE;
    assign do_call = cmd.call & ~cmd.ret;
    assign do_ret  = cmd.ret & ~cmd.call;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= WS_RUN;
            cwp  <= '0;
            mark <= MARK_RST;
        end else begin
            unique case (st)
                WS_RUN: begin
                    if (do_call) begin
                        if (cwp_dn == mark) st <= WS_SPILL;
                        else                cwp <= cwp_dn;
                    end else if (do_ret) begin
                        if (cwp_up == mark) st <= WS_FILL;
                        else                cwp <= cwp_up;
                    end
                end
                WS_SPILL: begin
                    if (cmd.ack) begin
                        mark <= mark - ONE;
                        cwp  <= cwp_dn;
                        st   <= WS_RUN;
                    end
                end
                WS_FILL: begin
                    if (cmd.ack) begin
                        mark <= mark + ONE;
                        cwp  <= cwp_up;
                        st   <= WS_RUN;
                    end
                end
                default: st <= WS_RUN;
            endcase
        end
    end

    always_comb begin
        cwp_o      = cwp;
        ovf_o      = (st == WS_SPILL);
        unf_o      = (st == WS_FILL);
        trap_win_o = '0;
        if (st == WS_SPILL) trap_win_o = mark - ONE;
        if (st == WS_FILL)  trap_win_o = mark;
    end
endmodule

// File: rtl/rwin_store.sv
module rwin_store #(
    parameter int NPHYS = 138,
    parameter int PW    = 8,
    parameter int DW    = 32,
    parameter int NRD   = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [PW-1:0]            wp,
    input  logic [DW-1:0]            wd,
    input  logic [NRD-1:0][PW-1:0]   rp,
    output logic [NRD-1:0][DW-1:0]   rdata
);
    logic [DW-1:0] mem [NPHYS];
    logic          wr_ok;

    // physical 0 is the hardwired zero register
    assign wr_ok = we && (wp != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NPHYS; i++) mem[i] <= '0;
        end else if (wr_ok) begin
            mem[wp] <= wd;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        always_comb begin
            if (rp[g] == '0)                 rdata[g] = '0;
            else if (wr_ok && (rp[g] == wp)) rdata[g] = wd;
            else                             rdata[g] = mem[rp[g]];
        end
    end
endmodule

// File: rtl/rwin_regfile.sv
module rwin_regfile
    import rwin_pkg::*;
#(
    parameter int NWIN  = DEF_NWIN,
    parameter int NGLOB = DEF_NGLOB,
    parameter int NIO   = DEF_NIO,
    parameter int NLOC  = DEF_NLOC,
    parameter int DW    = DEF_DW
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      call_i,
    input  logic                      ret_i,
    input  logic                      ack_i,
    input  logic [4:0]                ra_i,
    input  logic [4:0]                rb_i,
    output logic [DW-1:0]             rd_a_o,
    output logic [DW-1:0]             rd_b_o,
    input  logic                      we_i,
    input  logic [4:0]                wa_i,
    input  logic [DW-1:0]             wd_i,
    output logic [$clog2(NWIN)-1:0]   cwp_o,
    output logic                      ovf_o,
    output logic                      unf_o,
    output logic [$clog2(NWIN)-1:0]   trap_win_o
);
    localparam int WW    = $clog2(NWIN);
    localparam int BANK  = NIO + NLOC;
    localparam int NPHYS = NGLOB + NWIN * BANK;
    localparam int PW    = $clog2(NPHYS);
    localparam int NMAP  = 3;
    localparam int NRD   = 2;

    win_cmd_t                     cmd;
    logic [NMAP-1:0][LAW-1:0]     laddr;
    logic [NMAP-1:0][PW-1:0]      paddr;
    logic [NRD-1:0][PW-1:0]       rp;
    logic [NRD-1:0][DW-1:0]       rdata;

    assign cmd   = '{call: call_i, ret: ret_i, ack: ack_i};
    assign laddr = {wa_i, rb_i, ra_i};

    rwin_ctrl #(
        .NWIN (NWIN),
        .WW   (WW),
        .MARK0(1)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .cwp_o     (cwp_o),
        .ovf_o     (ovf_o),
        .unf_o     (unf_o),
        .trap_win_o(trap_win_o)
    );

    for (genvar g = 0; g < NMAP; g++) begin : g_map
        rwin_map #(
            .NWIN (NWIN),
            .NGLOB(NGLOB),
            .NIO  (NIO),
            .NLOC (NLOC),
            .WW   (WW),
            .PW   (PW)
        ) u_map (
            .lreg(laddr[g]),
            .cwp (cwp_o),
            .preg(paddr[g])
        );
    end

    assign rp = {paddr[1], paddr[0]};

    rwin_store #(
        .NPHYS(NPHYS),
        .PW   (PW),
        .DW   (DW),
        .NRD  (NRD)
    ) u_store (
        .clk  (clk),
        .rst  (rst),
        .we   (we_i),
        .wp   (paddr[2]),
        .wd   (wd_i),
        .rp   (rp),
        .rdata(rdata)
    );

    assign rd_a_o = rdata[0];
    assign rd_b_o = rdata[1];
endmodule

// File: rtl/rwin_chk.sv
module rwin_chk #(
    parameter int DW = 32,
    parameter int WW = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          call_i,
    input logic          ret_i,
    input logic          ack_i,
    input logic [4:0]    ra_i,
    input logic          we_i,
    input logic [4:0]    wa_i,
    input logic [DW-1:0] wd_i,
    input logic [DW-1:0] rd_a_o,
    input logic [WW-1:0] cwp_o,
    input logic          ovf_o,
    input logic          unf_o
);
    localparam logic [WW-1:0] ONE = WW'(1);

    // R2: r0 reads zero
    a_r2_zero_reg: assert property (@(posedge clk) disable iff (rst)
        (ra_i == 5'd0) |-> (rd_a_o == '0));

    // R3: same-cycle write forwarded to the read port
    a_r3_bypass: assert property (@(posedge clk) disable iff (rst)
        (we_i && wa_i != 5'd0 && ra_i == wa_i) |-> (rd_a_o == wd_i));

    // R5: accepted call moves the pointer down or traps
    a_r5_call_step: assert property (@(posedge clk) disable iff (rst)
        (!ovf_o && !unf_o && call_i && !ret_i)
            |=> (ovf_o || cwp_o == ($past(cwp_o) - ONE)));

    // R7: overflow holds with a frozen pointer until acknowledged
    a_r7_ovf_hold: assert property (@(posedge clk) disable iff (rst)
        (ovf_o && !ack_i) |=> (ovf_o && $stable(cwp_o)));

    // R8: acknowledge completes the call
    a_r8_ovf_ack: assert property (@(posedge clk) disable iff (rst)
        (ovf_o && ack_i) |=> (!ovf_o && cwp_o == ($past(cwp_o) - ONE)));

    // R9: acknowledge completes the return
    a_r9_unf_ack: assert property (@(posedge clk) disable iff (rst)
        (unf_o && ack_i) |=> (!unf_o && cwp_o == ($past(cwp_o) + ONE)));

    // R10: simultaneous call and return leaves the pointer alone
    a_r10_both_strobes: assert property (@(posedge clk) disable iff (rst)
        (!ovf_o && !unf_o && call_i && ret_i) |=> ($stable(cwp_o) && !ovf_o && !unf_o));

    // R7, R9: never both traps
    a_r7_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(ovf_o && unf_o));
endmodule

bind rwin_regfile rwin_chk #(.DW(DW), .WW(WW)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .call_i(call_i),
    .ret_i (ret_i),
    .ack_i (ack_i),
    .ra_i  (ra_i),
    .we_i  (we_i),
    .wa_i  (wa_i),
    .wd_i  (wd_i),
    .rd_a_o(rd_a_o),
    .cwp_o (cwp_o),
    .ovf_o (ovf_o),
    .unf_o (unf_o)
);

// File: tb/rwin_regfile_tb.sv
module rwin_regfile_tb;
    localparam int DW = 32;
    localparam int NP = 138;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          call_i = 0, ret_i = 0, ack_i = 0, we_i = 0;
    logic [4:0]    ra_i = 0, rb_i = 0, wa_i = 0;
    logic [DW-1:0] wd_i = 0;
    logic [DW-1:0] rd_a_o, rd_b_o;
    logic [2:0]    cwp_o, trap_win_o;
    logic          ovf_o, unf_o;

    always #10 clk = ~clk;

    rwin_regfile u_dut (
        .clk(clk), .rst(rst), .call_i(call_i), .ret_i(ret_i), .ack_i(ack_i),
        .ra_i(ra_i), .rb_i(rb_i), .rd_a_o(rd_a_o), .rd_b_o(rd_b_o),
        .we_i(we_i), .wa_i(wa_i), .wd_i(wd_i), .cwp_o(cwp_o),
        .ovf_o(ovf_o), .unf_o(unf_o), .trap_win_o(trap_win_o)
    );

    logic [DW-1:0] m_mem [NP];
    int m_cwp, m_mark, m_st;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    function automatic int phys(int r, int w);
        if (r < 10) return r;
        if (r < 16) return 10 + ((w + 7) % 8) * 16 + (r - 10);
        if (r < 26) return 10 + w * 16 + 6 + (r - 16);
        return 10 + w * 16 + (r - 26);
    endfunction

    task automatic chk(string tag, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] exp_rd(int a);
        if (a == 0) return '0;
        if (we_i && int'(wa_i) == a) return wd_i;
        return m_mem[phys(a, m_cwp)];
    endfunction

    function automatic string rtag(int a);
        if (a == 0) return "R2 read";
        if (we_i && int'(wa_i) == a) return "R3 bypass";
        if (a < 10) return "R1 global";
        return "R4 window";
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NP; i++) m_mem[i] = '0;
        m_cwp = 0; m_mark = 1; m_st = 0;
    endtask

    task automatic step(bit c, bit r, bit k, bit w, int wa, logic [DW-1:0] wd, int ra, int rb);
        bit ic;
        bit ir;
        @(negedge clk);
        call_i = c; ret_i = r; ack_i = k; we_i = w;
        wa_i = 5'(wa); wd_i = wd; ra_i = 5'(ra); rb_i = 5'(rb);
        #2;
        chk("R5 cwp", cwp_o, m_cwp);
        chk("R7 ovf", ovf_o, m_st == 1);
        chk("R9 unf", unf_o, m_st == 2);
        chk("R7 trap_win", trap_win_o,
            (m_st == 1) ? (m_mark + 7) % 8 : (m_st == 2) ? m_mark : 0);
        chk(rtag(ra), rd_a_o, exp_rd(ra));
        chk(rtag(rb), rd_b_o, exp_rd(rb));
        @(posedge clk);
        #1;
        if (w && wa != 0) m_mem[phys(wa, m_cwp)] = wd;
        ic = c && !r;
        ir = r && !c;
        case (m_st)
            0: begin
                if (ic) begin
                    if ((m_cwp + 7) % 8 == m_mark) m_st = 1;
                    else m_cwp = (m_cwp + 7) % 8;
                end else if (ir) begin
                    if ((m_cwp + 1) % 8 == m_mark) m_st = 2;
                    else m_cwp = (m_cwp + 1) % 8;
                end
            end
            1: if (k) begin m_mark = (m_mark + 7) % 8; m_cwp = (m_cwp + 7) % 8; m_st = 0; end
            2: if (k) begin m_mark = (m_mark + 1) % 8; m_cwp = (m_cwp + 1) % 8; m_st = 0; end
            default: m_st = 0;
        endcase
    endtask

    task automatic idle_rd(int ra, int rb);
        step(0, 0, 0, 0, 0, '0, ra, rb);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1b5e_ed01));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #2;
        // R6 reset state
        chk("R6 cwp", cwp_o, 0);
        chk("R6 ovf", ovf_o, 0);
        chk("R6 unf", unf_o, 0);
        chk("R6 trap_win", trap_win_o, 0);
        ra_i = 5'd20; rb_i = 5'd5;
        #1;
        chk("R6 reg zero", rd_a_o, 0);
        chk("R6 reg zero", rd_b_o, 0);

        // R2 write to r0 dropped
        step(0, 0, 0, 1, 0, 32'hdead_beef, 0, 0);
        idle_rd(0, 0);
        chk("R2 r0 after write", rd_a_o, 0);

        // R1 global visible after a call
        step(0, 0, 0, 1, 3, 32'h0000_1234, 3, 0);
        step(0, 0, 0, 1, 12, 32'h0000_0abc, 0, 0);
        step(0, 0, 0, 1, 18, 32'h0000_5555, 0, 0);
        step(1, 0, 0, 0, 0, '0, 0, 0);
        idle_rd(3, 28);
        chk("R1 global after call", rd_a_o, 32'h1234);
        chk("R4 caller out is callee in", rd_b_o, 32'h0abc);
        idle_rd(18, 12);
        chk("R4 locals private", rd_a_o, 0);
        step(0, 0, 0, 0, 0, '0, 0, 0);
        // R10 both strobes
        step(1, 1, 0, 0, 0, '0, 0, 0);
        idle_rd(0, 0);
        chk("R10 call+ret ignored", cwp_o, 7);
        // R10 ack with nothing pending
        step(0, 0, 1, 0, 0, '0, 0, 0);
        idle_rd(0, 0);
        chk("R10 stray ack ignored", cwp_o, 7);
        // return to window 0 and check its local survived
        step(0, 1, 0, 0, 0, '0, 0, 0);
        idle_rd(18, 0);
        chk("R4 local kept", rd_a_o, 32'h5555);

        // R7/R8 overflow walk: 6 calls fit, 7th traps
        for (int i = 0; i < 7; i++) step(1, 0, 0, 0, 0, '0, 0, 0);
        idle_rd(0, 0);
        chk("R7 ovf raised", ovf_o, 1);
        chk("R7 spill window", trap_win_o, 0);
        step(1, 0, 0, 0, 0, '0, 0, 0);
        step(0, 1, 0, 0, 0, '0, 0, 0);
        idle_rd(0, 0);
        chk("R10 strobes ignored in trap", cwp_o, 2);
        step(0, 0, 1, 0, 0, '0, 0, 0);
        idle_rd(0, 0);
        chk("R8 call done after ack", cwp_o, 1);
        chk("R8 ovf cleared", ovf_o, 0);
        // R9 underflow at moved mark (window 0)
        for (int i = 0; i < 7; i++) step(0, 1, 0, 0, 0, '0, 0, 0);
        idle_rd(0, 0);
        chk("R9 unf raised", unf_o, 1);
        chk("R9 fill window", trap_win_o, 0);
        step(0, 0, 1, 0, 0, '0, 0, 0);
        idle_rd(0, 0);
        chk("R9 return done after ack", cwp_o, 0);

        // random phase
        for (int n = 0; n < 3000; n++) begin
            bit c, r, k, w;
            int wa, ra, rb;
            c  = ($urandom % 100) < 30;
            r  = ($urandom % 100) < 28;
            k  = (m_st != 0) ? (($urandom % 100) < 40) : (($urandom % 100) < 5);
            w  = ($urandom % 100) < 60;
            wa = int'($urandom % 32);
            ra = (($urandom % 100) < 15) ? wa : int'($urandom % 32);
            rb = int'($urandom % 32);
            step(c, r, k, w, wa, $urandom, ra, rb);
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule